// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Stage

This block is the fetch stage for an instruction set whose instructions are 1 to 8 bytes long, with the byte count encoded in the first byte of each instruction. Each cycle it puts a fetch address on a byte-addressed instruction memory port. The port returns, in the same cycle, a window of nine consecutive bytes starting at that address. The stage registers the current instruction into a decode latch. The instruction bytes are left-aligned and unused byte lanes are zeroed.

The stage always reads one byte past the end of the current instruction. That surplus byte is normally the first byte of the next instruction, and it is kept in a register. In the following cycle the length of that instruction is already known at the start of the cycle. The next fetch address is then a single add of the register contents to the current address, and consecutive instructions leave the stage at one per cycle. After reset or a redirect, nothing is latched yet, so the stage spends one bubble cycle reading the first byte before it fetches at full rate. A stall freezes the whole stage. A redirect loads a new fetch address and throws away the surplus byte.

Top module: `vlf_fetch_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stage clears `dec_valid_o` and sets `fetch_addr_o` to the parameter `RESET_ADDR`.
- R2: Window byte k (bits `[8k+7:8k]` of `fetch_win_i`) is memory byte `fetch_addr_o + k`, for k = 0 to 8. The low three bits v of an instruction's first byte give a length of v+1 bytes, so 000 means 1 and 111 means 8. `dec_len_o` reports this length.
- R3: After reset is released, or after a redirect, the first edge is a bubble: `dec_valid_o` is 0 and `fetch_addr_o` does not move. The instruction at the start address appears valid after the second edge.
- R4: `dec_bytes_o` holds instruction byte j in bits `[8j+7:8j]` for j < length. Every byte lane at or beyond the length is zero, and `dec_addr_o` is the instruction's address.
- R5: Once running with no stall and no redirect, a valid instruction appears after every edge. Each instruction's address equals the previous address plus the previous length, and `fetch_addr_o` moves the same way. Addresses wrap modulo 2^ADDR_W.
- R6: An edge with `stall_i` high and `redir_i` low leaves `fetch_addr_o` and all decode outputs unchanged. It also keeps the latched surplus byte.
- R7: An edge with `redir_i` high, whether or not stalled, sets `fetch_addr_o` to `redir_addr_i` and clears `dec_valid_o`. It discards the latched surplus byte, so R3's bubble follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Hold the whole stage this cycle |
| redir_i | input | 1 | Load a new fetch address (branch target) |
| redir_addr_i | input | ADDR_W | Target address for a redirect |
| fetch_addr_o | output | ADDR_W | Address of the first byte of the memory window |
| fetch_win_i | input | 8*(2^LEN_BITS+1) | Nine-byte window read at `fetch_addr_o`, same cycle |
| dec_valid_o | output | 1 | Decode latch holds a real instruction |
| dec_addr_o | output | ADDR_W | Address of the latched instruction |
| dec_len_o | output | LEN_BITS+1 | Length of the latched instruction in bytes |
| dec_bytes_o | output | 8*2^LEN_BITS | Instruction bytes, left-aligned, unused lanes zero |

## Verification
The bench drives inputs on the falling edge and runs a reference model of the latch and fetch address alongside the design. The model is advanced by exactly one rising edge per cycle. Decode outputs are due one edge after the fetch that produced them. The first instruction after reset or a redirect is due two edges later, because of the bubble. A stall's effect shows after the single edge it covers. Every output is compared against the model at the next falling edge, so each result is checked in the cycle it becomes due and never earlier.

// File: rtl/vlf_pkg.sv
`timescale 1ns/1ps
// Package: shared byte type and the length-field decoding rule for the
// variable-length fetch stage. Assumes the length lives in the low bits
// of an instruction's first byte and encodes (value + 1) bytes.
package vlf_pkg;
    typedef logic [7:0] byte_t;

    // Decode a first byte into a byte count of width lb+1.
    function automatic logic [7:0] field_len(input byte_t b, input int lb);
        logic [7:0] mask;
        mask = 8'((1 << lb) - 1);
        return (b & mask) + 8'd1;
    endfunction
endpackage

// File: rtl/vlf_len_decode.sv
`timescale 1ns/1ps
// Module: vlf_len_decode
// Turns a latched first byte into an instruction length (1..2^LEN_BITS).
// Assumes the input byte was registered, so this sits at the very start
// of the cycle's critical path.
module vlf_len_decode #(
    parameter int LEN_BITS = 3,
    localparam int CNT_W   = LEN_BITS + 1
) (
    input  vlf_pkg::byte_t   first_i,
    output logic [CNT_W-1:0] len_o
);
    logic [7:0] wide_len;

    // Apply the shared decoding rule and trim to the count width.
    always_comb begin
        wide_len = vlf_pkg::field_len(first_i, LEN_BITS);
        len_o    = wide_len[CNT_W-1:0];
    end
endmodule

// File: rtl/vlf_window_split.sv
`timescale 1ns/1ps
// Module: vlf_window_split
// Splits the memory window into the current instruction (left-aligned,
// lanes past the length forced to zero) and the surplus byte just past
// its end. Assumes len_i is in 1..MAX_LEN.
module vlf_window_split #(
    parameter int LEN_BITS = 3,
    localparam int MAX_LEN = 1 << LEN_BITS,
    localparam int WIN     = MAX_LEN + 1,
    localparam int CNT_W   = LEN_BITS + 1
) (
    input  logic [WIN*8-1:0]     win_i,
    input  logic [CNT_W-1:0]     len_i,
    output logic [MAX_LEN*8-1:0] ins_o,
    output vlf_pkg::byte_t       extra_o
);
    // One masking lane per instruction byte.
    for (genvar i = 0; i < MAX_LEN; i++) begin : g_lane
        assign ins_o[i*8 +: 8] = (CNT_W'(i) < len_i) ? win_i[i*8 +: 8] : 8'h00;
    end

    // Pick the byte that sits right after the instruction's last byte.
    always_comb begin
        extra_o = '0;
        for (int k = 1; k < WIN; k++) begin
            if (len_i == CNT_W'(k)) extra_o = win_i[k*8 +: 8];
        end
    end
endmodule

// File: rtl/vlf_pc_ctrl.sv
`timescale 1ns/1ps
// Module: vlf_pc_ctrl
// Holds the fetch address, the latched first byte of the instruction at
// that address, and a flag saying whether that byte is known. The next
// address is the current one plus the length decoded from the latched
// byte. Assumes redirect wins over stall.
module vlf_pc_ctrl #(
    parameter int              ADDR_W     = 32,
    parameter int              LEN_BITS   = 3,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int             CNT_W      = LEN_BITS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              redir_i,
    input  logic [ADDR_W-1:0] redir_addr_i,
    input  vlf_pkg::byte_t    win_first_i,
    input  vlf_pkg::byte_t    extra_i,
    input  logic [CNT_W-1:0]  len_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              rdy_o,
    output vlf_pkg::byte_t    first_o
);
    logic [ADDR_W-1:0] pc_q;
    logic              rdy_q;
    vlf_pkg::byte_t    first_q;

    // Advance, hold, or reload the fetch address and the latched byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= RESET_ADDR;
            rdy_q   <= 1'b0;
            first_q <= '0;
        end else if (redir_i) begin
            pc_q  <= redir_addr_i;
            rdy_q <= 1'b0;
        end else if (!stall_i) begin
            if (!rdy_q) begin
                first_q <= win_first_i;
                rdy_q   <= 1'b1;
            end else begin
                first_q <= extra_i;
                pc_q    <= pc_q + ADDR_W'(len_i);
            end
        end
    end

    assign pc_o    = pc_q;
    assign rdy_o   = rdy_q;
    assign first_o = first_q;

    // R3: a bubble cycle only captures the first byte; the address stays.
    p_bubble_holds_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_q && !stall_i && !redir_i) |=> (rdy_q && $stable(pc_q)));

    // R6: a stalled edge keeps the latched byte and its flag.
    p_stall_keeps_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !redir_i) |=> ($stable(first_q) && $stable(rdy_q)));
endmodule

// File: rtl/vlf_fetch_top.sv
`timescale 1ns/1ps
// Module: vlf_fetch_top
// Variable-length fetch stage. Reads a window one byte longer than the
// longest instruction, registers the current instruction into the
// decode latch and keeps the surplus byte for the next cycle's length.
// Assumes the memory port answers combinationally in the same cycle.
module vlf_fetch_top #(
    parameter int                ADDR_W     = 32,
    parameter int                LEN_BITS   = 3,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_1000,
    localparam int               MAX_LEN    = 1 << LEN_BITS,
    localparam int               WIN        = MAX_LEN + 1,
    localparam int               CNT_W      = LEN_BITS + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stall_i,
    input  logic                 redir_i,
    input  logic [ADDR_W-1:0]    redir_addr_i,
    output logic [ADDR_W-1:0]    fetch_addr_o,
    input  logic [WIN*8-1:0]     fetch_win_i,
    output logic                 dec_valid_o,
    output logic [ADDR_W-1:0]    dec_addr_o,
    output logic [CNT_W-1:0]     dec_len_o,
    output logic [MAX_LEN*8-1:0] dec_bytes_o
);
    logic [ADDR_W-1:0]    pc;
    logic                 rdy;
    vlf_pkg::byte_t       first_b;
    vlf_pkg::byte_t       extra_b;
    logic [CNT_W-1:0]     cur_len;
    logic [MAX_LEN*8-1:0] ins_bytes;

    vlf_len_decode #(.LEN_BITS(LEN_BITS)) u_len (
        .first_i (first_b),
        .len_o   (cur_len)
    );

    vlf_window_split #(.LEN_BITS(LEN_BITS)) u_split (
        .win_i   (fetch_win_i),
        .len_i   (cur_len),
        .ins_o   (ins_bytes),
        .extra_o (extra_b)
    );

    vlf_pc_ctrl #(.ADDR_W(ADDR_W), .LEN_BITS(LEN_BITS), .RESET_ADDR(RESET_ADDR)) u_pc (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall_i      (stall_i),
        .redir_i      (redir_i),
        .redir_addr_i (redir_addr_i),
        .win_first_i  (fetch_win_i[7:0]),
        .extra_i      (extra_b),
        .len_i        (cur_len),
        .pc_o         (pc),
        .rdy_o        (rdy),
        .first_o      (first_b)
    );

    assign fetch_addr_o = pc;

    // Decode latch: load on a ready fetch, clear on redirect, hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid_o <= 1'b0;
            dec_addr_o  <= '0;
            dec_len_o   <= '0;
            dec_bytes_o <= '0;
        end else if (redir_i) begin
            dec_valid_o <= 1'b0;
        end else if (!stall_i) begin
            dec_valid_o <= rdy;
            if (rdy) begin
                dec_addr_o  <= pc;
                dec_len_o   <= cur_len;
                dec_bytes_o <= ins_bytes;
            end
        end
    end

    // R5: consecutive instructions abut and arrive with no gap.
    p_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && !stall_i && !redir_i) |=>
        (dec_valid_o && dec_addr_o == $past(dec_addr_o + ADDR_W'(dec_len_o))));

    // R6: a stalled edge freezes the fetch address and the latch.
    p_stall_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !redir_i) |=>
        ($stable(fetch_addr_o) && $stable(dec_valid_o) && $stable(dec_addr_o)
         && $stable(dec_len_o) && $stable(dec_bytes_o)));

    // R7: a redirect lands on the target and drops the latch contents.
    p_redirect_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redir_i |=> (!dec_valid_o && fetch_addr_o == $past(redir_addr_i)));

    // R4: byte lanes beyond the reported length are zero.
    p_tail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> ((dec_bytes_o >> (32'(dec_len_o) * 8)) == '0));

    // R2: a valid length lies in 1..MAX_LEN.
    p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> (dec_len_o != '0 && 32'(dec_len_o) <= MAX_LEN));
endmodule

// File: tb/vlf_fetch_top_tb.sv
`timescale 1ns/1ps
module vlf_fetch_top_tb;
    localparam int          AW    = 32;
    localparam int          MAXL  = 8;
    localparam int          WINB  = MAXL + 1;
    localparam logic [31:0] RADDR = 32'h0000_1000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stall_i = 1'b0;
    logic             redir_i = 1'b0;
    logic [AW-1:0]    redir_addr_i = '0;
    logic [AW-1:0]    fetch_addr_o;
    logic [WINB*8-1:0] fetch_win_i;
    logic             dec_valid_o;
    logic [AW-1:0]    dec_addr_o;
    logic [3:0]       dec_len_o;
    logic [MAXL*8-1:0] dec_bytes_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    vlf_fetch_top #(.ADDR_W(AW), .LEN_BITS(3), .RESET_ADDR(RADDR)) u_dut (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .redir_i(redir_i),
        .redir_addr_i(redir_addr_i), .fetch_addr_o(fetch_addr_o),
        .fetch_win_i(fetch_win_i), .dec_valid_o(dec_valid_o),
        .dec_addr_o(dec_addr_o), .dec_len_o(dec_len_o), .dec_bytes_o(dec_bytes_o)
    );

    // Memory image: page 4 holds only length-8 bytes, page 5 only length-1 bytes.
    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        logic [31:0] h;
        if (a[31:12] == 20'h00004) return 8'hAF;
        if (a[31:12] == 20'h00005) return 8'hF8;
        h = a * 32'h9E37_79B1;
        return h[31:24] ^ h[7:0];
    endfunction

    always_comb begin
        for (int k = 0; k < WINB; k++) fetch_win_i[k*8 +: 8] = mem_byte(fetch_addr_o + 32'(k));
    end

    // Reference model state.
    logic [31:0] m_pc;
    bit          m_rdy;
    logic [7:0]  m_first;
    bit          e_valid;
    logic [31:0] e_addr;
    logic [3:0]  e_len;
    logic [63:0] e_bytes;
    string       tag;
    int          n_len8 = 0;
    int          n_len1 = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare the outputs with the model (called at a falling edge).
    task automatic compare();
        chk(dec_valid_o == e_valid, tag, 64'(dec_valid_o), 64'(e_valid));
        chk(fetch_addr_o == m_pc, tag, 64'(fetch_addr_o), 64'(m_pc));
        if (e_valid) begin
            chk(dec_addr_o == e_addr, "R5", 64'(dec_addr_o), 64'(e_addr));
            chk(dec_len_o == e_len, "R2", 64'(dec_len_o), 64'(e_len));
            chk(dec_bytes_o == e_bytes, "R4", dec_bytes_o, e_bytes);
            if (e_len == 4'd8) n_len8++;
            if (e_len == 4'd1) n_len1++;
        end
    endtask

    // Advance the model by one rising edge under the current inputs.
    task automatic model_step(input bit st, input bit rd, input logic [31:0] ra);
        int l;
        if (rd) begin
            m_pc = ra; m_rdy = 1'b0; e_valid = 1'b0; tag = "R7";
        end else if (st) begin
            tag = "R6";
        end else if (!m_rdy) begin
            m_first = mem_byte(m_pc); m_rdy = 1'b1; e_valid = 1'b0; tag = "R3";
        end else begin
            l = int'(m_first[2:0]) + 1;
            e_valid = 1'b1; e_addr = m_pc; e_len = 4'(l);
            e_bytes = '0;
            for (int j = 0; j < l; j++) e_bytes[j*8 +: 8] = mem_byte(m_pc + 32'(j));
            m_first = mem_byte(m_pc + 32'(l));
            m_pc = m_pc + 32'(l);
            tag = "R5";
        end
    endtask

    task automatic cycle(input bit st, input bit rd, input logic [31:0] ra);
        stall_i = st; redir_i = rd; redir_addr_i = ra;
        model_step(st, rd, ra);
        @(negedge clk);
        compare();
    endtask

    initial begin
        int seed;
        int r;
        seed = $urandom(4720);
        m_pc = RADDR; m_rdy = 1'b0; m_first = '0;
        e_valid = 1'b0; e_addr = '0; e_len = '0; e_bytes = '0; tag = "R1";
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(dec_valid_o == 1'b0, "R1", 64'(dec_valid_o), 64'd0);
        chk(fetch_addr_o == RADDR, "R1", 64'(fetch_addr_o), 64'(RADDR));
        rst_n = 1'b1;
        // R3: bubble after reset, then a straight run (R5).
        for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0, '0);
        // R2/R4 boundaries: all-length-8 page, then all-length-1 page.
        cycle(1'b0, 1'b1, 32'h0000_4000);
        for (int i = 0; i < 8; i++) cycle(1'b0, 1'b0, '0);
        cycle(1'b0, 1'b1, 32'h0000_5003);
        for (int i = 0; i < 8; i++) cycle(1'b0, 1'b0, '0);
        chk(n_len8 >= 6, "R2", 64'(n_len8), 64'd6);
        chk(n_len1 >= 6, "R4", 64'(n_len1), 64'd6);
        // R6: stall during bubble and during the run.
        cycle(1'b0, 1'b1, 32'h0000_2222);
        cycle(1'b1, 1'b0, '0);
        cycle(1'b0, 1'b0, '0);
        cycle(1'b0, 1'b0, '0);
        cycle(1'b1, 1'b0, '0);
        cycle(1'b1, 1'b0, '0);
        cycle(1'b0, 1'b0, '0);
        // R7: redirect while stalled; R5: wrap at the top of the address space.
        cycle(1'b1, 1'b1, 32'hFFFF_FFFC);
        for (int i = 0; i < 10; i++) cycle(1'b0, 1'b0, '0);
        // Constrained random mix.
        for (int i = 0; i < 4000; i++) begin
            bit st;
            bit rd;
            logic [31:0] ra;
            r  = int'($urandom_range(0, 99));
            st = (r < 20);
            rd = ($urandom_range(0, 99) < 4);
            r  = int'($urandom_range(0, 3));
            ra = (r == 0) ? 32'h0000_4000 + 32'($urandom_range(0, 255)) :
                 (r == 1) ? 32'h0000_5000 + 32'($urandom_range(0, 255)) :
                 (r == 2) ? 32'hFFFF_FFF0 + 32'($urandom_range(0, 15)) : $urandom;
            cycle(st, rd, ra);
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule